// File: doc/BRIEF.md
# FM Low-Frequency Modulation Source

This block is the slow oscillator that feeds tremolo and vibrato values to a bank of FM voices. It holds a 32-bit phase accumulator in 7.25 fixed point. On every output-sample strobe, and only while the oscillator is switched on, the accumulator adds a programmable increment. The top seven bits of the accumulator form an integer step, and the block derives two values from that step.

The amplitude value is a triangle. It rises over the first half of the step range, falls over the second half, and is doubled so that it covers the even numbers 0 to 126. The phase-modulation index is the step divided by four. Each output is a register that is rewritten only when the part of the step it depends on has changed since the previous sample. Between changes, the voices see steady values. When the oscillator is switched off, the accumulator freezes and both outputs fall to zero.

Top module: `fm_lfo`

## Requirements
- R1: After reset the accumulator, the amplitude output and the phase output are all zero.
- R2: On each clock edge where the enable and the sample strobe are both high, the accumulator becomes its old value plus the increment, modulo 2^32. The step is accumulator bits [31:25], so it wraps modulo 128.
- R3: On a clock edge with the enable high and the strobe low, the accumulator and both outputs keep their values.
- R4: The amplitude output depends on the new step s. For s < 64 it is 2*s. For s >= 64 it is 2*(63 - (s mod 64)). The value is therefore always even and never above 126.
- R5: On an advance, the amplitude output is rewritten only if the new step differs from the step before the advance. Otherwise it keeps its value.
- R6: On an advance, the phase output (5 bits) becomes s >> 2 only if s >> 2 differs from the old step >> 2. Otherwise it keeps its value.
- R7: On a clock edge with the enable low, both outputs become 0, the accumulator holds its value, and the strobe is ignored.
- R8: After the enable returns high, each output stays 0 until its own part of the step changes (R5, R6).
- R9: Each output changes on the clock edge that samples the strobe, so it is visible one edge after the strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lfoEn | input | 1 | Oscillator enable |
| sampleStb | input | 1 | One-cycle strobe, once per output sample |
| lfoInc | input | 32 | Phase increment per sample, 7.25 fixed point |
| amOut | output | 8 | Triangle amplitude value, even, 0..126 |
| pmOut | output | 5 | Phase-modulation index, step >> 2 |

## Verification
The embedded properties check these rules on every cycle:
- the amplitude output stays even and within range;
- without a strobe nothing moves;
- a disabled cycle clears both outputs and freezes the accumulator;
- a change in the phase output always matches the accumulator's top bits;
- the two control strobes never coincide.

The lazy rewrite rule can only be shown by the bench's scenarios. Those scenarios are a full walk through the triangle fold and wrap, fractional increments that leave the step unchanged for several samples, gaps in the strobe, and a disable and re-enable that leaves the outputs at zero until the step moves.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
  typedef struct packed {
    logic advance;
    logic clear;
  } lfoCtl_t;
endpackage

// File: rtl/lfo_ctrl.sv
module lfo_ctrl
  import lfo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lfoEn,
  input  logic    sampleStb,
  output lfoCtl_t ctl
);
  always_comb begin
    ctl.advance = lfoEn & sampleStb;
    ctl.clear   = ~lfoEn;
  end

  // R7: a disabled cycle never advances
  p_excl_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.advance, ctl.clear}));
endmodule

// File: rtl/lfo_datapath.sv
module lfo_datapath
  import lfo_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lfoCtl_t           ctl,
  input  logic [CNT_W-1:0]  inc,
  output logic [STEP_W:0]   amOut,
  output logic [STEP_W-3:0] pmOut
);
  localparam int AM_W   = STEP_W + 1;
  localparam int PM_W   = STEP_W - 2;
  localparam int HALF_W = STEP_W - 1;
  localparam logic [AM_W-1:0] AM_MAX = AM_W'(((2 ** HALF_W) - 1) * 2);

  logic [CNT_W-1:0]  cntQ, cntD;
  logic [STEP_W-1:0] stepOld, stepNew;
  logic [HALF_W-1:0] amBase;
  logic [AM_W-1:0]   amQ;
  logic [PM_W-1:0]   pmQ;

  always_comb begin
    cntD    = cntQ + inc;
    stepOld = cntQ[CNT_W-1 -: STEP_W];
    stepNew = cntD[CNT_W-1 -: STEP_W];
    amBase  = stepNew[HALF_W] ? ~stepNew[HALF_W-1:0] : stepNew[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
      amQ  <= '0;
      pmQ  <= '0;
    end else if (ctl.clear) begin
      amQ <= '0;
      pmQ <= '0;
    end else if (ctl.advance) begin
      cntQ <= cntD;
      if (stepNew != stepOld)
        amQ <= {1'b0, amBase, 1'b0};
      if (stepNew[STEP_W-1:2] != stepOld[STEP_W-1:2])
        pmQ <= stepNew[STEP_W-1:2];
    end
  end

  assign amOut = amQ;
  assign pmOut = pmQ;

  p_am_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (amQ[0] == 1'b0) && (amQ <= AM_MAX));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.advance && !ctl.clear) |=> ($stable(cntQ) && $stable(amQ) && $stable(pmQ)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (amQ == '0 && pmQ == '0 && $stable(cntQ)));

  p_pm_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.advance |=> (pmQ == $past(pmQ) || pmQ == cntQ[CNT_W-1 -: PM_W]));

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.advance |=> (cntQ == $past(cntQ) + $past(inc)));
endmodule

// File: rtl/fm_lfo.sv
module fm_lfo
  import lfo_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lfoEn,
  input  logic              sampleStb,
  input  logic [CNT_W-1:0]  lfoInc,
  output logic [STEP_W:0]   amOut,
  output logic [STEP_W-3:0] pmOut
);
  lfoCtl_t ctl;

  lfo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .lfoEn(lfoEn), .sampleStb(sampleStb), .ctl(ctl)
  );

  lfo_datapath #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .inc(lfoInc),
    .amOut(amOut), .pmOut(pmOut)
  );
endmodule

// File: tb/fm_lfo_tb.sv
module fm_lfo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lfoEn = 1'b0;
  logic        sampleStb = 1'b0;
  logic [31:0] lfoInc = '0;
  logic [7:0]  amOut;
  logic [4:0]  pmOut;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  longint mCnt = 0;
  int    mAm = 0, mPm = 0;
  bit    doneFlag = 1'b0;

  fm_lfo u_dut (.clk(clk), .rst_n(rst_n), .lfoEn(lfoEn), .sampleStb(sampleStb),
                .lfoInc(lfoInc), .amOut(amOut), .pmOut(pmOut));

  always #4 clk = ~clk;

  function automatic int triOf(int s);
    return (s < 64) ? 2 * s : 2 * (63 - (s % 64));
  endfunction

  // behavioural reference, updated on each edge from the inputs driven at negedge
  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = 0; mAm = 0; mPm = 0;
    end else if (!lfoEn) begin
      mAm = 0; mPm = 0;
    end else if (sampleStb) begin
      int oldS, newS;
      oldS = int'(mCnt >> 25);
      mCnt = (mCnt + longint'(lfoInc)) & 64'hFFFF_FFFF;
      newS = int'(mCnt >> 25);
      if (newS != oldS) mAm = triOf(newS);
      if ((newS >> 2) != (oldS >> 2)) mPm = newS >> 2;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge (R9 timing)
  always @(negedge clk) begin
    if (rst_n && !doneFlag) begin
      check(curReq, int'(amOut), mAm, "amOut");
      check(curReq, int'(pmOut), mPm, "pmOut");
    end
  end

  task automatic strobes(int n, int gap);
    for (int i = 0; i < n; i++) begin
      sampleStb = 1'b1;
      @(negedge clk);
      sampleStb = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(amOut), 0, "amOut after reset");
    check("R1", int'(pmOut), 0, "pmOut after reset");

    // R2 R4: one whole step per sample, walk past fold and wrap
    curReq = "R4";
    lfoEn = 1'b1;
    lfoInc = 32'h0200_0000;
    strobes(70, 0);
    check("R4", int'(amOut), 114, "amOut at step 70");
    check("R6", int'(pmOut), 17, "pmOut at step 70");
    curReq = "R2";
    strobes(60, 1);
    check("R2", int'(amOut), 4, "amOut after wrap to step 2");

    // R3: idle cycles without strobe
    curReq = "R3";
    repeat (6) @(negedge clk);

    // R5 R6: quarter-step increment, lazy rewrite
    curReq = "R5";
    lfoInc = 32'h0080_0000;
    strobes(40, 0);
    curReq = "R6";
    lfoInc = 32'h0000_1234;
    strobes(30, 2);

    // R7: disable with strobes present
    curReq = "R7";
    lfoEn = 1'b0;
    lfoInc = 32'h0200_0000;
    strobes(5, 0);
    check("R7", int'(amOut), 0, "amOut disabled");
    check("R7", int'(pmOut), 0, "pmOut disabled");

    // R8: re-enable, outputs remain 0 until the step moves
    curReq = "R8";
    lfoEn = 1'b1;
    lfoInc = 32'h0000_0100;
    strobes(3, 0);
    check("R8", int'(amOut), 0, "amOut after re-enable, step unchanged");
    lfoInc = 32'h0200_0000;
    strobes(1, 0);
    check("R8", int'(pmOut) + int'(amOut) > 0 ? 1 : 0, 1, "outputs move after step change");

    // R2: large and random increments, including near-wrap values
    curReq = "R2";
    lfoInc = 32'hFFFF_FFFF;
    strobes(10, 0);
    for (int k = 0; k < 200; k++) begin
      lfoInc = $urandom;
      lfoEn = ($urandom % 8) != 0;
      strobes(1, $urandom % 2);
    end

    // R1: synchronous reset mid-run
    curReq = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", int'(amOut), 0, "amOut after second reset");
    check("R1", int'(pmOut), 0, "pmOut after second reset");

    doneFlag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired, run hung");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule